// File: doc/BRIEF.md
# Multithreaded Fetch PC Sequencer

This block holds, for every hardware thread of an in-order pipeline with branch delay slots, the current fetch address and its next two successors. Each serviced fetch request gets an address, the two sequential addresses after it and a per-thread sequence number, and that thread's address triple then moves forward by one instruction. Fetch addresses, next addresses and sequence numbers all belong to the thread that requested the fetch.

Later stages report control instructions together with their predictions. A branch that has a delay slot arms a countdown, so the redirect to its target happens only after the delay-slot instruction has been fetched. An unresolved return blocks fetch for its thread and signals the reporting stage. A conditional branch predicted not taken asks for a squash. Squash redirects come in on several ports at once. Per thread only the oldest of them is kept, and it either reloads the triple or, when the delay slot has not been fetched yet, re-arms the countdown. Threads are started from an architectural-state port and can be stopped.

Top module: `fseq_pc_sequencer`

## Requirements
- R1: After reset every thread is inactive, no fetch is granted, and the first fetch of a thread after its activation carries sequence number 0.
- R2: A fetch is granted only when the requested thread is active and no activate, deactivate, squash or control report targets that thread in the same cycle. A fetch that is not granted changes nothing.
- R3: A granted fetch without redirect returns the stored address A, then A+4, A+8 and the thread's sequence counter. Afterwards the triple shifts (address takes next, next takes next-next, next-next grows by 4) and the counter grows by 1.
- R4: When the target-ready flag is set and the countdown is zero, a granted fetch returns the stored target T, T+4 and T+8. The triple then becomes T+4, T+8, T+12 and target-ready is cleared.
- R5: A granted fetch with a nonzero countdown decrements it. When it goes from 1 to 0, target-ready is set, so the next fetch redirects.
- R6: A control report predicted taken increments the countdown, stores the predicted target and raises squash_o with sequence number reported+1 and that target. A non-conditional-delay control report predicted not taken increments the countdown and stores the reported next-next address, without a squash. The countdown never exceeds its maximum.
- R7: A return predicted not taken makes its thread inactive and raises block_o with the reporting stage, which is remembered for that thread.
- R8: A conditional-delay control report predicted not taken raises squash_o with the reported sequence number and next-next address and changes no thread state.
- R9: A report whose control flag is clear has no effect on state or outputs.
- R10: Among the squash ports aimed at one thread in a cycle, the one with the smallest sequence number wins. On a tie the lower port index wins.
- R11: A winning squash whose sequence number equals the thread's counter sets the countdown to 1 and stores its target. Any other winning squash reloads the triple from its target and clears the countdown and target-ready. Both make the thread active, and if it was inactive, unblock_o pulses with the remembered stage.
- R12: Activation loads the triple from the activate port and makes the thread active. Deactivation makes it inactive and clears countdown, target-ready and the remembered stage.
- R13: Same-thread priority in a cycle: deactivate over activate over squash over control report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request |
| fetch_tid_i | input | TID_W | Requesting thread |
| fetch_grant_o | output | 1 | Request serviced this cycle |
| fetch_pc_o | output | ADDR_W | Fetch address |
| fetch_npc_o | output | ADDR_W | Fetch address + 4 |
| fetch_nnpc_o | output | ADDR_W | Fetch address + 8 |
| fetch_seq_o | output | SEQ_W | Sequence number of the fetched instruction |
| ctl_valid_i | input | 1 | Control report valid |
| ctl_tid_i | input | TID_W | Reported thread |
| ctl_stage_i | input | STAGE_W | Reporting stage |
| ctl_is_ctrl_i | input | 1 | Instruction is a control transfer |
| ctl_is_ret_i | input | 1 | Instruction is a return |
| ctl_cond_ds_i | input | 1 | Conditional with delay slot skipped when not taken |
| ctl_taken_i | input | 1 | Predicted taken |
| ctl_pred_tgt_i | input | ADDR_W | Predicted target |
| ctl_nnpc_i | input | ADDR_W | Next-next address of the instruction |
| ctl_seq_i | input | SEQ_W | Sequence number of the instruction |
| block_o | output | 1 | Block fetch toward reporting stage |
| block_stage_o | output | STAGE_W | Stage to block |
| squash_o | output | 1 | Squash request |
| squash_seq_o | output | SEQ_W | Squash sequence number |
| squash_tgt_o | output | ADDR_W | Squash redirect address |
| sq_valid_i | input | NUM_SQ | Squash port valid |
| sq_tid_i | input | NUM_SQ x TID_W | Squash thread per port |
| sq_seq_i | input | NUM_SQ x SEQ_W | Squash sequence number per port |
| sq_tgt_i | input | NUM_SQ x ADDR_W | Squash target per port |
| unblock_o | output | NUM_THREADS | Unblock pulse per thread |
| unblock_stage_o | output | NUM_THREADS x STAGE_W | Stage to unblock per thread |
| act_i | input | 1 | Activate thread |
| act_tid_i | input | TID_W | Thread to activate |
| act_pc_i | input | ADDR_W | Address to load |
| act_npc_i | input | ADDR_W | Next address to load |
| act_nnpc_i | input | ADDR_W | Next-next address to load |
| deact_i | input | 1 | Deactivate thread |
| deact_tid_i | input | TID_W | Thread to deactivate |

## Verification
The assertions assume that the pipeline never arms more delay-slot countdowns on a thread than the counter can hold. The bench's reference model tracks each thread's countdown and turns any report that would overflow it into an idle slot. The post-fetch properties assume a thread's address triple moves only through this block's own update rules, which holds because every change comes through the ports. Random squash sequence numbers are often set equal to the modelled counter so that the pending path is exercised as well as the reload path.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int unsigned INSN_BYTES = 4;

  typedef enum logic [2:0] {
    CTL_NONE   = 3'd0,
    CTL_BLOCK  = 3'd1,
    CTL_SKIP   = 3'd2,
    CTL_ARM_NT = 3'd3,
    CTL_ARM_TK = 3'd4
  } ctl_act_e;
endpackage

// File: rtl/fseq_ctl_decode.sv
module fseq_ctl_decode
  import fseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SEQ_W  = 32
) (
  input  logic              valid_i,
  input  logic              is_ctrl_i,
  input  logic              is_ret_i,
  input  logic              cond_ds_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] pred_tgt_i,
  input  logic [ADDR_W-1:0] nnpc_i,
  input  logic [SEQ_W-1:0]  seq_i,
  output ctl_act_e          act_o,
  output logic [ADDR_W-1:0] arm_tgt_o,
  output logic              squash_o,
  output logic [SEQ_W-1:0]  squash_seq_o,
  output logic [ADDR_W-1:0] squash_tgt_o
);
  always_comb begin
    act_o        = CTL_NONE;
    arm_tgt_o    = nnpc_i;
    squash_o     = 1'b0;
    squash_seq_o = seq_i;
    squash_tgt_o = nnpc_i;
    if (valid_i && is_ctrl_i) begin
      if (is_ret_i && !taken_i) begin
        act_o = CTL_BLOCK;
      end else if (cond_ds_i && !taken_i) begin
        act_o    = CTL_SKIP;
        squash_o = 1'b1;
      end else if (!taken_i) begin
        act_o = CTL_ARM_NT;
      end else begin
        act_o        = CTL_ARM_TK;
        arm_tgt_o    = pred_tgt_i;
        squash_o     = 1'b1;
        squash_seq_o = seq_i + SEQ_W'(1);  // delay slot survives
        squash_tgt_o = pred_tgt_i;
      end
    end
  end
endmodule

// File: rtl/fseq_squash_filter.sv
module fseq_squash_filter #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned NUM_SQ      = 2,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SEQ_W       = 32,
  localparam int unsigned TID_W      = $clog2(NUM_THREADS)
) (
  input  logic [NUM_SQ-1:0]                 sq_valid_i,
  input  logic [NUM_SQ-1:0][TID_W-1:0]      sq_tid_i,
  input  logic [NUM_SQ-1:0][SEQ_W-1:0]      sq_seq_i,
  input  logic [NUM_SQ-1:0][ADDR_W-1:0]     sq_tgt_i,
  output logic [NUM_THREADS-1:0]            win_o,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0] win_seq_o,
  output logic [NUM_THREADS-1:0][ADDR_W-1:0] win_tgt_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_comb begin
      win_o[t]     = 1'b0;
      win_seq_o[t] = '0;
      win_tgt_o[t] = '0;
      // earlier port keeps a tie; a later one replaces only if strictly older
      for (int p = 0; p < NUM_SQ; p++) begin
        if (sq_valid_i[p] && (sq_tid_i[p] == TID_W'(t)) &&
            (!win_o[t] || (sq_seq_i[p] < win_seq_o[t]))) begin
          win_o[t]     = 1'b1;
          win_seq_o[t] = sq_seq_i[p];
          win_tgt_o[t] = sq_tgt_i[p];
        end
      end
    end
  end
endmodule

// File: rtl/fseq_thread.sv
module fseq_thread
  import fseq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SEQ_W    = 32,
  parameter int unsigned STAGE_W  = 3,
  parameter int unsigned DS_CNT_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_req_i,
  input  logic               ctl_hit_i,
  input  ctl_act_e           ctl_act_i,
  input  logic [ADDR_W-1:0]  arm_tgt_i,
  input  logic [STAGE_W-1:0] ctl_stage_i,
  input  logic               sq_win_i,
  input  logic [SEQ_W-1:0]   sq_seq_i,
  input  logic [ADDR_W-1:0]  sq_tgt_i,
  input  logic               act_i,
  input  logic [ADDR_W-1:0]  act_pc_i,
  input  logic [ADDR_W-1:0]  act_npc_i,
  input  logic [ADDR_W-1:0]  act_nnpc_i,
  input  logic               deact_i,
  output logic               grant_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [SEQ_W-1:0]   seq_o,
  output logic               unblock_o,
  output logic [STAGE_W-1:0] unblock_stage_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0]   pc_q, npc_q, nnpc_q, tgt_q;
  logic [SEQ_W-1:0]    seq_q;
  logic [DS_CNT_W-1:0] cnt_q;
  logic                tgt_rdy_q, pc_valid_q;
  logic [STAGE_W-1:0]  blk_stage_q;

  logic other_ev, fetch_go, redirect, sq_take, sq_pending, arm;

  assign other_ev   = ctl_hit_i | sq_win_i | act_i | deact_i;
  assign fetch_go   = fetch_req_i & pc_valid_q & ~other_ev;
  assign redirect   = tgt_rdy_q & (cnt_q == '0);
  assign sq_take    = sq_win_i & ~act_i & ~deact_i;
  assign sq_pending = (seq_q == sq_seq_i);
  assign arm        = ctl_hit_i & ((ctl_act_i == CTL_ARM_NT) | (ctl_act_i == CTL_ARM_TK));

  assign grant_o         = fetch_go;
  assign pc_o            = redirect ? tgt_q : pc_q;
  assign seq_o           = seq_q;
  assign unblock_o       = sq_take & ~pc_valid_q;
  assign unblock_stage_o = blk_stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q        <= '0;
      npc_q       <= '0;
      nnpc_q      <= '0;
      tgt_q       <= '0;
      seq_q       <= '0;
      cnt_q       <= '0;
      tgt_rdy_q   <= 1'b0;
      pc_valid_q  <= 1'b0;
      blk_stage_q <= '0;
    end else if (deact_i) begin
      cnt_q       <= '0;
      tgt_rdy_q   <= 1'b0;
      pc_valid_q  <= 1'b0;
      blk_stage_q <= '0;
    end else if (act_i) begin
      pc_q       <= act_pc_i;
      npc_q      <= act_npc_i;
      nnpc_q     <= act_nnpc_i;
      pc_valid_q <= 1'b1;
    end else if (sq_take) begin
      tgt_rdy_q  <= 1'b0;
      pc_valid_q <= 1'b1;
      if (sq_pending) begin
        // delay slot not yet fetched: let it issue, then redirect
        cnt_q <= DS_CNT_W'(1);
        tgt_q <= sq_tgt_i;
      end else begin
        cnt_q  <= '0;
        pc_q   <= sq_tgt_i;
        npc_q  <= sq_tgt_i + STEP;
        nnpc_q <= sq_tgt_i + (STEP << 1);
      end
    end else if (ctl_hit_i) begin
      if (ctl_act_i == CTL_BLOCK) begin
        pc_valid_q  <= 1'b0;
        blk_stage_q <= ctl_stage_i;
      end else if (arm) begin
        cnt_q     <= cnt_q + DS_CNT_W'(1);
        tgt_rdy_q <= 1'b0;
        tgt_q     <= arm_tgt_i;
      end
    end else if (fetch_go) begin
      seq_q <= seq_q + SEQ_W'(1);
      if (redirect) begin
        pc_q      <= tgt_q + STEP;
        npc_q     <= tgt_q + (STEP << 1);
        nnpc_q    <= tgt_q + (STEP << 1) + STEP;
        tgt_rdy_q <= 1'b0;
      end else begin
        pc_q   <= npc_q;
        npc_q  <= nnpc_q;
        nnpc_q <= nnpc_q + STEP;
      end
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - DS_CNT_W'(1);
        if (cnt_q == DS_CNT_W'(1)) tgt_rdy_q <= 1'b1;
      end
    end
  end

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_go |=> (seq_q == $past(seq_q) + SEQ_W'(1)));  // R3

  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && !pc_valid_q && !other_ev) |=> ($stable(pc_q) && $stable(seq_q) && $stable(cnt_q)));  // R2

  AST_DS_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_go && redirect) |=> (!tgt_rdy_q && (pc_q == $past(tgt_q) + STEP)));  // R4

  AST_CNT_ZERO_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_go && (cnt_q == DS_CNT_W'(1))) |=> (tgt_rdy_q && (cnt_q == '0)));  // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm && !sq_win_i && !act_i && !deact_i) |-> (cnt_q != '1));  // R6

  AST_SQ_ACTIVATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_take |=> pc_valid_q);  // R11

  AST_DEACT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_i |=> (!pc_valid_q && (cnt_q == '0) && !tgt_rdy_q));  // R12
endmodule

// File: rtl/fseq_pc_sequencer.sv
module fseq_pc_sequencer
  import fseq_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned NUM_SQ      = 2,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SEQ_W       = 32,
  parameter int unsigned STAGE_W     = 3,
  parameter int unsigned DS_CNT_W    = 2,
  localparam int unsigned TID_W      = $clog2(NUM_THREADS)
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   fetch_req_i,
  input  logic [TID_W-1:0]                       fetch_tid_i,
  output logic                                   fetch_grant_o,
  output logic [ADDR_W-1:0]                      fetch_pc_o,
  output logic [ADDR_W-1:0]                      fetch_npc_o,
  output logic [ADDR_W-1:0]                      fetch_nnpc_o,
  output logic [SEQ_W-1:0]                       fetch_seq_o,
  input  logic                                   ctl_valid_i,
  input  logic [TID_W-1:0]                       ctl_tid_i,
  input  logic [STAGE_W-1:0]                     ctl_stage_i,
  input  logic                                   ctl_is_ctrl_i,
  input  logic                                   ctl_is_ret_i,
  input  logic                                   ctl_cond_ds_i,
  input  logic                                   ctl_taken_i,
  input  logic [ADDR_W-1:0]                      ctl_pred_tgt_i,
  input  logic [ADDR_W-1:0]                      ctl_nnpc_i,
  input  logic [SEQ_W-1:0]                       ctl_seq_i,
  output logic                                   block_o,
  output logic [STAGE_W-1:0]                     block_stage_o,
  output logic                                   squash_o,
  output logic [SEQ_W-1:0]                       squash_seq_o,
  output logic [ADDR_W-1:0]                      squash_tgt_o,
  input  logic [NUM_SQ-1:0]                      sq_valid_i,
  input  logic [NUM_SQ-1:0][TID_W-1:0]           sq_tid_i,
  input  logic [NUM_SQ-1:0][SEQ_W-1:0]           sq_seq_i,
  input  logic [NUM_SQ-1:0][ADDR_W-1:0]          sq_tgt_i,
  output logic [NUM_THREADS-1:0]                 unblock_o,
  output logic [NUM_THREADS-1:0][STAGE_W-1:0]    unblock_stage_o,
  input  logic                                   act_i,
  input  logic [TID_W-1:0]                       act_tid_i,
  input  logic [ADDR_W-1:0]                      act_pc_i,
  input  logic [ADDR_W-1:0]                      act_npc_i,
  input  logic [ADDR_W-1:0]                      act_nnpc_i,
  input  logic                                   deact_i,
  input  logic [TID_W-1:0]                       deact_tid_i
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  ctl_act_e          ctl_act;
  logic [ADDR_W-1:0] arm_tgt;

  logic [NUM_THREADS-1:0]             win;
  logic [NUM_THREADS-1:0][SEQ_W-1:0]  win_seq;
  logic [NUM_THREADS-1:0][ADDR_W-1:0] win_tgt;

  logic [NUM_THREADS-1:0]             grant_v;
  logic [NUM_THREADS-1:0][ADDR_W-1:0] pc_v;
  logic [NUM_THREADS-1:0][SEQ_W-1:0]  seq_v;

  fseq_ctl_decode #(.ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_dec (
    .valid_i      (ctl_valid_i),
    .is_ctrl_i    (ctl_is_ctrl_i),
    .is_ret_i     (ctl_is_ret_i),
    .cond_ds_i    (ctl_cond_ds_i),
    .taken_i      (ctl_taken_i),
    .pred_tgt_i   (ctl_pred_tgt_i),
    .nnpc_i       (ctl_nnpc_i),
    .seq_i        (ctl_seq_i),
    .act_o        (ctl_act),
    .arm_tgt_o    (arm_tgt),
    .squash_o     (squash_o),
    .squash_seq_o (squash_seq_o),
    .squash_tgt_o (squash_tgt_o)
  );

  fseq_squash_filter #(
    .NUM_THREADS(NUM_THREADS), .NUM_SQ(NUM_SQ), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
  ) u_filt (
    .sq_valid_i (sq_valid_i),
    .sq_tid_i   (sq_tid_i),
    .sq_seq_i   (sq_seq_i),
    .sq_tgt_i   (sq_tgt_i),
    .win_o      (win),
    .win_seq_o  (win_seq),
    .win_tgt_o  (win_tgt)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    fseq_thread #(
      .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .STAGE_W(STAGE_W), .DS_CNT_W(DS_CNT_W)
    ) u_thr (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .fetch_req_i     (fetch_req_i && (fetch_tid_i == TID_W'(t))),
      .ctl_hit_i       (ctl_valid_i && (ctl_tid_i == TID_W'(t))),
      .ctl_act_i       (ctl_act),
      .arm_tgt_i       (arm_tgt),
      .ctl_stage_i     (ctl_stage_i),
      .sq_win_i        (win[t]),
      .sq_seq_i        (win_seq[t]),
      .sq_tgt_i        (win_tgt[t]),
      .act_i           (act_i && (act_tid_i == TID_W'(t))),
      .act_pc_i        (act_pc_i),
      .act_npc_i       (act_npc_i),
      .act_nnpc_i      (act_nnpc_i),
      .deact_i         (deact_i && (deact_tid_i == TID_W'(t))),
      .grant_o         (grant_v[t]),
      .pc_o            (pc_v[t]),
      .seq_o           (seq_v[t]),
      .unblock_o       (unblock_o[t]),
      .unblock_stage_o (unblock_stage_o[t])
    );
  end

  assign fetch_grant_o = grant_v[fetch_tid_i];
  assign fetch_pc_o    = pc_v[fetch_tid_i];
  assign fetch_npc_o   = fetch_pc_o + STEP;
  assign fetch_nnpc_o  = fetch_pc_o + (STEP << 1);
  assign fetch_seq_o   = seq_v[fetch_tid_i];

  assign block_o       = (ctl_act == CTL_BLOCK);
  assign block_stage_o = block_o ? ctl_stage_i : '0;

  AST_BLOCK_NO_SQUASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> !squash_o);  // R7

  AST_GRANT_ONE_THREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_v));  // R2
endmodule

// File: tb/fseq_pc_sequencer_test.sv
module fseq_pc_sequencer_test;
  localparam int NT = 4;
  localparam int NSQ = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              fetch_req;
  logic [1:0]        fetch_tid;
  logic              fetch_grant;
  logic [31:0]       fetch_pc, fetch_npc, fetch_nnpc, fetch_seq;
  logic              ctl_valid, ctl_is_ctrl, ctl_is_ret, ctl_cond_ds, ctl_taken;
  logic [1:0]        ctl_tid;
  logic [2:0]        ctl_stage;
  logic [31:0]       ctl_pred_tgt, ctl_nnpc, ctl_seq;
  logic              block, squash;
  logic [2:0]        block_stage;
  logic [31:0]       squash_seq, squash_tgt;
  logic [NSQ-1:0]    sq_valid;
  logic [NSQ-1:0][1:0]  sq_tid;
  logic [NSQ-1:0][31:0] sq_seq, sq_tgt;
  logic [NT-1:0]     unblock;
  logic [NT-1:0][2:0] unblock_stage;
  logic              act, deact;
  logic [1:0]        act_tid, deact_tid;
  logic [31:0]       act_pc, act_npc, act_nnpc;

  fseq_pc_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_tid_i(fetch_tid), .fetch_grant_o(fetch_grant),
    .fetch_pc_o(fetch_pc), .fetch_npc_o(fetch_npc), .fetch_nnpc_o(fetch_nnpc), .fetch_seq_o(fetch_seq),
    .ctl_valid_i(ctl_valid), .ctl_tid_i(ctl_tid), .ctl_stage_i(ctl_stage),
    .ctl_is_ctrl_i(ctl_is_ctrl), .ctl_is_ret_i(ctl_is_ret), .ctl_cond_ds_i(ctl_cond_ds),
    .ctl_taken_i(ctl_taken), .ctl_pred_tgt_i(ctl_pred_tgt), .ctl_nnpc_i(ctl_nnpc), .ctl_seq_i(ctl_seq),
    .block_o(block), .block_stage_o(block_stage),
    .squash_o(squash), .squash_seq_o(squash_seq), .squash_tgt_o(squash_tgt),
    .sq_valid_i(sq_valid), .sq_tid_i(sq_tid), .sq_seq_i(sq_seq), .sq_tgt_i(sq_tgt),
    .unblock_o(unblock), .unblock_stage_o(unblock_stage),
    .act_i(act), .act_tid_i(act_tid), .act_pc_i(act_pc), .act_npc_i(act_npc), .act_nnpc_i(act_nnpc),
    .deact_i(deact), .deact_tid_i(deact_tid)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_pc[NT], m_npc[NT], m_nnpc[NT], m_tgt[NT], m_seq[NT];
  int          m_cnt[NT], m_blk[NT];
  bit          m_tr[NT], m_valid[NT];
  // per-cycle derived values
  bit          w_hit[NT];
  logic [31:0] w_seq[NT], w_tgt[NT];
  int          e_kind;  // 0 none 1 block 2 skip 3 arm-nt 4 arm-taken

  task automatic chk(input string req, input logic [31:0] actv, input logic [31:0] expv);
    n_chk++;
    if (actv !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, actv, expv);
    end
  endtask

  task automatic idle();
    fetch_req = 0; fetch_tid = 0;
    ctl_valid = 0; ctl_tid = 0; ctl_stage = 0; ctl_is_ctrl = 0; ctl_is_ret = 0;
    ctl_cond_ds = 0; ctl_taken = 0; ctl_pred_tgt = 0; ctl_nnpc = 0; ctl_seq = 0;
    sq_valid = '0; sq_tid = '0; sq_seq = '0; sq_tgt = '0;
    act = 0; act_tid = 0; act_pc = 0; act_npc = 0; act_nnpc = 0;
    deact = 0; deact_tid = 0;
  endtask

  function automatic bit ev_on(int t);
    return (ctl_valid && ctl_tid == t) || w_hit[t] || (act && act_tid == t) || (deact && deact_tid == t);
  endfunction

  // settle, then compare every output against the model
  task automatic eval_cmp();
    bit eg, rd, eu;
    logic [31:0] ep;
    #5;
    for (int t = 0; t < NT; t++) begin
      w_hit[t] = 0; w_seq[t] = 0; w_tgt[t] = 0;
      for (int p = 0; p < NSQ; p++)
        if (sq_valid[p] && sq_tid[p] == t && (!w_hit[t] || sq_seq[p] < w_seq[t])) begin
          w_hit[t] = 1; w_seq[t] = sq_seq[p]; w_tgt[t] = sq_tgt[p];
        end
    end
    e_kind = 0;
    if (ctl_valid && ctl_is_ctrl) begin
      if (ctl_is_ret && !ctl_taken) e_kind = 1;
      else if (ctl_cond_ds && !ctl_taken) e_kind = 2;
      else if (!ctl_taken) e_kind = 3;
      else e_kind = 4;
    end
    eg = fetch_req && m_valid[fetch_tid] && !ev_on(fetch_tid);
    chk("R2 grant", fetch_grant, eg);
    if (eg) begin
      rd = m_tr[fetch_tid] && m_cnt[fetch_tid] == 0;
      ep = rd ? m_tgt[fetch_tid] : m_pc[fetch_tid];
      chk("R3 pc", fetch_pc, ep);
      chk("R3 npc", fetch_npc, ep + 4);
      chk("R3 nnpc", fetch_nnpc, ep + 8);
      chk("R3 seq", fetch_seq, m_seq[fetch_tid]);
    end
    chk("R7 block", block, e_kind == 1);
    if (e_kind == 1) chk("R7 stage", block_stage, ctl_stage);
    chk("R6 squash", squash, e_kind == 2 || e_kind == 4);
    if (e_kind == 2) begin
      chk("R8 squash seq", squash_seq, ctl_seq);
      chk("R8 squash tgt", squash_tgt, ctl_nnpc);
    end
    if (e_kind == 4) begin
      chk("R6 squash seq", squash_seq, ctl_seq + 1);
      chk("R6 squash tgt", squash_tgt, ctl_pred_tgt);
    end
    for (int t = 0; t < NT; t++) begin
      eu = w_hit[t] && !(act && act_tid == t) && !(deact && deact_tid == t) && !m_valid[t];
      chk("R11 unblock", unblock[t], eu);
      if (eu) chk("R11 unblock stage", unblock_stage[t], m_blk[t]);
    end
  endtask

  task automatic tick();
    for (int t = 0; t < NT; t++) begin
      if (deact && deact_tid == t) begin
        m_cnt[t] = 0; m_tr[t] = 0; m_valid[t] = 0; m_blk[t] = 0;
      end else if (act && act_tid == t) begin
        m_pc[t] = act_pc; m_npc[t] = act_npc; m_nnpc[t] = act_nnpc; m_valid[t] = 1;
      end else if (w_hit[t]) begin
        m_tr[t] = 0; m_valid[t] = 1;
        if (w_seq[t] == m_seq[t]) begin
          m_cnt[t] = 1; m_tgt[t] = w_tgt[t];
        end else begin
          m_cnt[t] = 0; m_pc[t] = w_tgt[t]; m_npc[t] = w_tgt[t] + 4; m_nnpc[t] = w_tgt[t] + 8;
        end
      end else if (ctl_valid && ctl_tid == t) begin
        if (e_kind == 1) begin
          m_valid[t] = 0; m_blk[t] = ctl_stage;
        end else if (e_kind >= 3) begin
          m_cnt[t]++; m_tr[t] = 0;
          m_tgt[t] = (e_kind == 4) ? ctl_pred_tgt : ctl_nnpc;
        end
      end else if (fetch_req && fetch_tid == t && m_valid[t]) begin
        if (m_tr[t] && m_cnt[t] == 0) begin
          m_pc[t] = m_tgt[t] + 4; m_npc[t] = m_tgt[t] + 8; m_nnpc[t] = m_tgt[t] + 12; m_tr[t] = 0;
        end else begin
          m_pc[t] = m_npc[t]; m_npc[t] = m_nnpc[t]; m_nnpc[t] = m_nnpc[t] + 4;
        end
        if (m_cnt[t] != 0) begin
          m_cnt[t]--;
          if (m_cnt[t] == 0) m_tr[t] = 1;
        end
        m_seq[t] = m_seq[t] + 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_fetch(input int t);
    fetch_req = 1; fetch_tid = 2'(t);
  endtask

  task automatic do_ctl(input int t, input bit c, input bit r, input bit cd, input bit tk,
                        input logic [31:0] pt, input logic [31:0] nn, input logic [31:0] s, input int st);
    ctl_valid = 1; ctl_tid = 2'(t); ctl_is_ctrl = c; ctl_is_ret = r; ctl_cond_ds = cd;
    ctl_taken = tk; ctl_pred_tgt = pt; ctl_nnpc = nn; ctl_seq = s; ctl_stage = 3'(st);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      m_pc[t] = 0; m_npc[t] = 0; m_nnpc[t] = 0; m_tgt[t] = 0; m_seq[t] = 0;
      m_cnt[t] = 0; m_blk[t] = 0; m_tr[t] = 0; m_valid[t] = 0;
    end
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: inactive after reset
    do_fetch(0); eval_cmp(); chk("R1 grant after reset", fetch_grant, 0); tick();
    // R12: activation loads triple
    act = 1; act_tid = 1; act_pc = 32'h100; act_npc = 32'h104; act_nnpc = 32'h108;
    eval_cmp(); tick();
    do_fetch(1); eval_cmp(); chk("R12 loaded pc", fetch_pc, 32'h100); chk("R1 first seq", fetch_seq, 0); tick();
    do_fetch(1); eval_cmp(); chk("R3 pc", fetch_pc, 32'h104); chk("R3 nnpc", fetch_nnpc, 32'h10C);
    chk("R3 seq", fetch_seq, 1); tick();
    // R6: taken branch arms the countdown
    do_ctl(1, 1, 0, 0, 1, 32'h400, 32'h10C, 1, 2); eval_cmp();
    chk("R6 squash", squash, 1); chk("R6 squash seq", squash_seq, 2); tick();
    do_fetch(1); eval_cmp(); chk("R5 delay slot pc", fetch_pc, 32'h108); tick();
    do_fetch(1); eval_cmp(); chk("R4 target pc", fetch_pc, 32'h400); chk("R4 npc", fetch_npc, 32'h404); tick();
    do_fetch(1); eval_cmp(); chk("R4 after target", fetch_pc, 32'h404); tick();
    // R9: non-control report ignored
    do_ctl(1, 0, 1, 1, 1, 32'h777, 32'h888, 5, 1); eval_cmp();
    chk("R9 no squash", squash, 0); chk("R9 no block", block, 0); tick();
    do_fetch(1); eval_cmp(); chk("R9 pc untouched", fetch_pc, 32'h408); tick();
    // R8: conditional-delay not taken
    do_ctl(1, 1, 0, 1, 0, 32'h999, 32'h410, 5, 2); eval_cmp();
    chk("R8 squash", squash, 1); chk("R8 seq", squash_seq, 5); chk("R8 tgt", squash_tgt, 32'h410); tick();
    do_fetch(1); eval_cmp(); chk("R8 state kept", fetch_pc, 32'h40C); tick();
    // R7: unresolved return blocks
    do_ctl(1, 1, 1, 0, 0, 0, 0, 6, 3); eval_cmp();
    chk("R7 block", block, 1); chk("R7 stage", block_stage, 3); tick();
    do_fetch(1); eval_cmp(); chk("R2 blocked stall", fetch_grant, 0); tick();
    // R10/R11: oldest squash wins and unblocks
    sq_valid = 2'b11; sq_tid[0] = 1; sq_seq[0] = 100; sq_tgt[0] = 32'h900;
    sq_tid[1] = 1; sq_seq[1] = 90; sq_tgt[1] = 32'hA00;
    eval_cmp(); chk("R11 unblock", unblock[1], 1); chk("R11 stage", unblock_stage[1], 3); tick();
    do_fetch(1); eval_cmp(); chk("R10 oldest wins", fetch_pc, 32'hA00); tick();
    // R10 tie and R11 pending path
    sq_valid = 2'b11; sq_tid[0] = 1; sq_seq[0] = m_seq[1]; sq_tgt[0] = 32'hC00;
    sq_tid[1] = 1; sq_seq[1] = m_seq[1]; sq_tgt[1] = 32'hD00;
    eval_cmp(); chk("R11 no unblock when active", unblock[1], 0); tick();
    do_fetch(1); eval_cmp(); chk("R11 pending slot", fetch_pc, 32'hA04); tick();
    do_fetch(1); eval_cmp(); chk("R10 tie lower port", fetch_pc, 32'hC00); tick();
    // R13: priorities
    act = 1; act_tid = 2; act_pc = 32'h2000; act_npc = 32'h2004; act_nnpc = 32'h2008;
    deact = 1; deact_tid = 2; eval_cmp(); tick();
    do_fetch(2); eval_cmp(); chk("R13 deact over act", fetch_grant, 0); tick();
    act = 1; act_tid = 2; act_pc = 32'h2000; act_npc = 32'h2004; act_nnpc = 32'h2008;
    sq_valid = 2'b01; sq_tid[0] = 2; sq_seq[0] = 50; sq_tgt[0] = 32'h3000;
    eval_cmp(); chk("R13 no unblock under act", unblock[2], 0); tick();
    do_fetch(2); eval_cmp(); chk("R13 act over squash", fetch_pc, 32'h2000); tick();
    // R12: deactivation
    deact = 1; deact_tid = 1; eval_cmp(); tick();
    do_fetch(1); eval_cmp(); chk("R12 deactivated", fetch_grant, 0); tick();

    // random phase, compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      int t;
      if ($urandom % 100 < 75) do_fetch($urandom % NT);
      if ($urandom % 100 < 12) begin
        bit c, r, cd, tk, arming;
        t = $urandom % NT;
        c = ($urandom % 4) != 0; r = ($urandom % 4) == 0; cd = ($urandom % 3) == 0; tk = $urandom % 2;
        arming = c && !(r && !tk) && !(cd && !tk);
        if (!(arming && m_cnt[t] >= 3))
          do_ctl(t, c, r, cd, tk, $urandom & 32'hFFFC, $urandom & 32'hFFFC, m_seq[t], $urandom % 8);
      end
      for (int p = 0; p < NSQ; p++)
        if ($urandom % 100 < 6) begin
          t = $urandom % NT;
          sq_valid[p] = 1; sq_tid[p] = 2'(t); sq_tgt[p] = $urandom & 32'hFFFC;
          sq_seq[p] = ($urandom % 2) ? m_seq[t] : m_seq[t] + ($urandom % 3);
        end
      if ($urandom % 100 < 5) begin
        act = 1; act_tid = 2'($urandom % NT); act_pc = $urandom & 32'hFFFC;
        act_npc = act_pc + 4; act_nnpc = act_pc + 8;
      end
      if ($urandom % 100 < 2) begin
        deact = 1; deact_tid = 2'($urandom % NT);
      end
      eval_cmp();
      tick();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule